// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block keeps a free-running counter and a match register of the same width. Together they raise a timer interrupt. A tick-enable input, pulsed once per period of a fixed time base, advances the counter. Because of this, the count rate does not depend on the core clock. When an increment brings the counter to the value held in the match register, an internal pending flag is set. The flag drives one of eight interrupt lines, and the line is picked at run time by a 3-bit select input. A build parameter decides whether the pending flag is also reported on its own output.

Software writes the match register to acknowledge the interrupt. That write is the only way to clear the pending flag. Software can load the counter at any time and can read it back at any time. A hold input freezes the counter. While the hold is set, no match can fire.

Top module: `ctimer_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it, the counter, the match register, the pending flag, `timerPend` and all `irqLines` are zero.
- R2: On each clock edge with `tickEn` high, `countHold` low and `cntWrEn` low, `cntRdData` increases by exactly one. Without `tickEn` it keeps its value.
- R3: While `countHold` is high, `tickEn` has no effect. The counter keeps its value, and no match sets the pending flag.
- R4: When an accepted tick makes the counter equal to the match register, the pending flag is set at that same clock edge.
- R5: The pending flag stays set through any number of later ticks, hold changes and counter writes, until the match register is written.
- R6: A write to the match register (`cmpWrEn`) clears the pending flag at that edge. If a match occurs in the same cycle, the write wins and the flag ends up clear.
- R7: A counter write (`cntWrEn`) loads `cntWrData` at that edge, takes priority over a tick in the same cycle, and counting continues from the loaded value.
- R8: `irqLines` is one-hot while the flag is pending. Bit `lineSel` (0 to 7) is set, and it follows `lineSel` combinationally. All bits are zero when the flag is not pending.
- R9: With `REV2_EN` = 1, `timerPend` equals the pending flag. With `REV2_EN` = 0, `timerPend` stays 0 while `irqLines` is still driven.
- R10: The counter wraps modulo 2^CNT_W. A match value just past the wrap point is reached by increments through zero.
- R11: Loading the counter with a value equal to the match register does not set the pending flag. Only an accepted increment does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Time-base tick, one pulse per count period |
| countHold | input | 1 | Freeze counter and suppress matches |
| lineSel | input | 3 | Selects which interrupt line is driven |
| cntWrEn | input | 1 | Load strobe for the counter |
| cntWrData | input | 32 | Value loaded into the counter |
| cmpWrEn | input | 1 | Load strobe for the match register; acknowledges the interrupt |
| cmpWrData | input | 32 | Value loaded into the match register |
| cntRdData | output | 32 | Current counter value |
| timerPend | output | 1 | Pending flag, reported only when REV2_EN = 1 |
| irqLines | output | 8 | One-hot interrupt lines |

## Verification
The bench builds two copies side by side from the same stimulus. One uses `REV2_EN` = 1, which makes the pending flag visible on `timerPend`. The other uses `REV2_EN` = 0, which shows that the interrupt lines still assert while the flag output stays low. Both copies keep the default 32-bit width and eight lines. The counter can be loaded directly, so loads near 2^32-1 reach the wrap-around match without long counting. Sweeping `lineSel` over all eight values covers every decoder output.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadCount;
    logic incCount;
    logic loadCmp;
  } ctlStrobes_t;
endpackage

// File: rtl/ctimer_ctrl.sv
module ctimer_ctrl
  import ctimer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        countHold,
  input  logic        cntWrEn,
  input  logic        cmpWrEn,
  input  logic        hitNext,
  output ctlStrobes_t strb,
  output logic        pendQ
);
  logic setPend;
  logic clrPend;

  always_comb begin
    strb.loadCount = cntWrEn;
    // A counter load pre-empts the tick; a hold blocks it
    strb.incCount  = tickEn && !countHold && !cntWrEn;
    strb.loadCmp   = cmpWrEn;
    clrPend        = cmpWrEn;
    setPend        = strb.incCount && hitNext;
  end

  // Clear has priority over a match in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (clrPend) begin
      pendQ <= 1'b0;
    end else if (setPend) begin
      pendQ <= 1'b1;
    end
  end
endmodule

// File: rtl/ctimer_dp.sv
module ctimer_dp
  import ctimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LINE_N = 8,
  parameter int SEL_W  = $clog2(LINE_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic [CNT_W-1:0]  cmpWrData,
  input  logic [SEL_W-1:0]  lineSel,
  input  logic              pendQ,
  output logic [CNT_W-1:0]  countQ,
  output logic              hitNext,
  output logic [LINE_N-1:0] irqLines
);
  logic [CNT_W-1:0] cmpQ;
  logic [CNT_W-1:0] countInc;

  // Modulo-2^CNT_W increment; the carry out is dropped
  assign countInc = countQ + CNT_W'(1);
  assign hitNext  = (countInc == cmpQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.loadCount) begin
      countQ <= cntWrData;
    end else if (strb.incCount) begin
      countQ <= countInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else if (strb.loadCmp) begin
      cmpQ <= cmpWrData;
    end
  end

  // Line decoder: one gate per output line
  for (genvar g = 0; g < LINE_N; g++) begin : gLine
    assign irqLines[g] = pendQ && (lineSel == SEL_W'(g));
  end
endmodule

// File: rtl/ctimer_top.sv
module ctimer_top
  import ctimer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int LINE_N  = 8,
  parameter bit REV2_EN = 1'b1,
  localparam int SEL_W  = $clog2(LINE_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              countHold,
  input  logic [SEL_W-1:0]  lineSel,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              cmpWrEn,
  input  logic [CNT_W-1:0]  cmpWrData,
  output logic [CNT_W-1:0]  cntRdData,
  output logic              timerPend,
  output logic [LINE_N-1:0] irqLines
);
  ctlStrobes_t strb;
  logic        pendQ;
  logic        hitNext;

  ctimer_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .countHold (countHold),
    .cntWrEn   (cntWrEn),
    .cmpWrEn   (cmpWrEn),
    .hitNext   (hitNext),
    .strb      (strb),
    .pendQ     (pendQ)
  );

  ctimer_dp #(
    .CNT_W  (CNT_W),
    .LINE_N (LINE_N),
    .SEL_W  (SEL_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cntWrData (cntWrData),
    .cmpWrData (cmpWrData),
    .lineSel   (lineSel),
    .pendQ     (pendQ),
    .countQ    (cntRdData),
    .hitNext   (hitNext),
    .irqLines  (irqLines)
  );

  if (REV2_EN) begin : gPendOut
    assign timerPend = pendQ;
  end else begin : gPendOff
    assign timerPend = 1'b0;
  end
endmodule

// File: rtl/ctimer_chk.sv
module ctimer_chk #(
  parameter int CNT_W   = 32,
  parameter int LINE_N  = 8,
  parameter bit REV2_EN = 1'b1,
  parameter int SEL_W   = $clog2(LINE_N)
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              countHold,
  input logic [SEL_W-1:0]  lineSel,
  input logic              cntWrEn,
  input logic [CNT_W-1:0]  cntWrData,
  input logic              cmpWrEn,
  input logic [CNT_W-1:0]  cmpWrData,
  input logic [CNT_W-1:0]  cntRdData,
  input logic              timerPend,
  input logic [LINE_N-1:0] irqLines
);
  assert_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !countHold && !cntWrEn) |=> cntRdData == $past(cntRdData) + CNT_W'(1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (countHold && !cntWrEn) |=> $stable(cntRdData));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((|irqLines) && !cmpWrEn) |=> (|irqLines));

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmpWrEn |=> (irqLines == '0));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> cntRdData == $past(cntWrData));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));

  assert_pend_report_R9: assert property (@(posedge clk) disable iff (!rstN)
    timerPend == (REV2_EN ? (|irqLines) : 1'b0));
endmodule

bind ctimer_top ctimer_chk #(
  .CNT_W   (CNT_W),
  .LINE_N  (LINE_N),
  .REV2_EN (REV2_EN)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .countHold (countHold),
  .lineSel   (lineSel),
  .cntWrEn   (cntWrEn),
  .cntWrData (cntWrData),
  .cmpWrEn   (cmpWrEn),
  .cmpWrData (cmpWrData),
  .cntRdData (cntRdData),
  .timerPend (timerPend),
  .irqLines  (irqLines)
);

// File: tb/ctimer_top_tb_top.sv
module ctimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        countHold = 1'b0;
  logic [2:0]  lineSel = '0;
  logic        cntWrEn = 1'b0;
  logic [31:0] cntWrData = '0;
  logic        cmpWrEn = 1'b0;
  logic [31:0] cmpWrData = '0;
  logic [31:0] cntRd, cntRdB;
  logic        tiA, tiB;
  logic [7:0]  linesA, linesB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctimer_top #(.REV2_EN(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .countHold(countHold),
    .lineSel(lineSel), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .cntRdData(cntRd), .timerPend(tiA), .irqLines(linesA));

  ctimer_top #(.REV2_EN(1'b0)) dutNoRev_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .countHold(countHold),
    .lineSel(lineSel), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .cntRdData(cntRdB), .timerPend(tiB), .irqLines(linesB));

  typedef struct {
    logic [31:0] cnt;
    logic [7:0]  lines;
    logic        pend;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference model state
  logic [31:0] mCount = '0;
  logic [31:0] mCmp = '0;
  logic        mPend = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, push what the next edge must yield
  task automatic step(input bit tk, input bit hd, input logic [2:0] sl,
                      input bit cw, input logic [31:0] cwd,
                      input bit pw, input logic [31:0] pwd, input string tg);
    expItem_t it;
    bit inc;
    @(negedge clk);
    tickEn = tk; countHold = hd; lineSel = sl;
    cntWrEn = cw; cntWrData = cwd; cmpWrEn = pw; cmpWrData = pwd;
    inc = tk && !hd && !cw;
    if (pw) mPend = 1'b0;
    else if (inc && (mCount + 32'd1 == mCmp)) mPend = 1'b1;
    if (cw) mCount = cwd;
    else if (inc) mCount = mCount + 32'd1;
    if (pw) mCmp = pwd;
    it.cnt = mCount;
    it.pend = mPend;
    it.lines = mPend ? (8'd1 << sl) : 8'd0;
    it.tag = tg;
    expQ.push_back(it);
  endtask

  task automatic idle(input logic [2:0] sl, input string tg);
    step(0, 0, sl, 0, '0, 0, '0, tg);
  endtask

  task automatic ticks(input int n, input string tg);
    for (int i = 0; i < n; i++) step(1, 0, 3'd2, 0, '0, 0, '0, tg);
  endtask

  // Monitor: compare both copies after each edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(cntRd == e.cnt, {e.tag, " count"}, cntRd, e.cnt);
      check(linesA == e.lines, {e.tag, " lines"}, {24'd0, linesA}, {24'd0, e.lines});
      check(tiA == e.pend, {e.tag, " R9 pend rev2"}, {31'd0, tiA}, {31'd0, e.pend});
      check(tiB == 1'b0, {e.tag, " R9 pend off"}, {31'd0, tiB}, 32'd0);
      check(linesB == e.lines, {e.tag, " R9 lines off"}, {24'd0, linesB}, {24'd0, e.lines});
    end
  end

  task automatic checkReset(input string tg);
    check(cntRd == '0 && cntRdB == '0, {tg, " R1 count"}, cntRd, 32'd0);
    check(tiA == 1'b0, {tg, " R1 pend"}, {31'd0, tiA}, 32'd0);
    check(linesA == '0 && linesB == '0, {tg, " R1 lines"}, {24'd0, linesA}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 checkReset("reset");
    @(negedge clk) rstN = 1'b1;
    idle(3'd0, "R1 post-reset");

    // R2: counting only on ticks
    ticks(5, "R2 tick");
    idle(3'd0, "R2 no tick");
    step(1, 0, 3'd0, 0, '0, 0, '0, "R2 tick");

    // R7: load wins over tick, counting resumes
    step(1, 0, 3'd0, 1, 32'd100, 0, '0, "R7 load");
    step(0, 0, 3'd0, 0, '0, 1, 32'd103, "R7 set cmp");
    ticks(2, "R7 resume");
    // R4: third increment hits 103
    ticks(1, "R4 match");
    // R5: stays pending
    ticks(4, "R5 sticky");
    step(0, 1, 3'd2, 0, '0, 0, '0, "R5 hold");
    step(0, 0, 3'd2, 1, 32'd7, 0, '0, "R5 cnt write");
    // R8: sweep line select
    for (int s = 0; s < 8; s++) idle(3'(s), "R8 sel");
    // R6: acknowledge
    step(0, 0, 3'd5, 0, '0, 1, 32'd50, "R6 ack");
    step(1, 0, 3'd5, 1, 32'd49, 0, '0, "R6 setup");
    step(1, 0, 3'd5, 0, '0, 1, 32'd50, "R6 ack beats match");
    idle(3'd5, "R6 after");

    // R3: hold blocks counting and match
    step(0, 0, 3'd1, 1, 32'd199, 1, 32'd200, "R3 setup");
    for (int i = 0; i < 4; i++) step(1, 1, 3'd1, 0, '0, 0, '0, "R3 held");
    step(1, 0, 3'd1, 0, '0, 0, '0, "R3 released");
    step(0, 0, 3'd1, 0, '0, 1, 32'd300, "R3 ack");

    // R11: direct load to compare value
    step(0, 0, 3'd4, 1, 32'd300, 0, '0, "R11 load eq");
    idle(3'd4, "R11 idle");

    // R10: wrap
    step(0, 0, 3'd6, 1, 32'hFFFF_FFFE, 1, 32'h0000_0001, "R10 setup");
    for (int i = 0; i < 3; i++) step(1, 0, 3'd6, 0, '0, 0, '0, "R10 wrap");
    idle(3'd7, "R10 pending");

    // R1: reset clears a pending, loaded state
    @(negedge clk);
    tickEn = 0; cntWrEn = 0; cmpWrEn = 0; rstN = 1'b0;
    mCount = '0; mCmp = '0; mPend = 1'b0;
    @(posedge clk); #2 checkReset("R1 re-reset");
    @(negedge clk) rstN = 1'b1;
    ticks(1, "R1 after re-reset");
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule